// File: doc/BRIEF.md
# Extreme-Pair Position-Map Key Extractor

This block turns a set of noisy per-cell counts into key bits that stay stable under repeated measurement. Each count arrives with a 16-bit cell position. During enrollment the block ranks all cells, then repeatedly takes the smallest remaining cell and the largest remaining cell. Each such pair yields one key bit, and the pair's two positions go out as helper data. Because the two positions in a pair are always emitted in ascending order, the helper stream reveals which cells were used but not which of them held the larger count.

During regeneration the same cell counts are loaded again and the stored helper stream is fed back in. The block looks up the count at each given position and recomputes every key bit. Unchanged counts give back the enrollment key exactly. Selection is sequential: each pick scans the stored cells once, so one enrollment takes about 2·K·N cycles.

Top module: `pmk_key_extractor`

## Requirements
- R1: A pulse on start_i while busy_o is low begins a run and raises busy_o on the next cycle. start_i is ignored while busy_o is high. After start, exactly N_CELLS beats on cnt_valid_i load the counts (cnt_i) and their positions (pos_i), in beat order.
- R2: Cells are ranked by count. Equal counts are ranked by position, with the lower position counting as the smaller value. For pair i, the low cell is the smallest cell not yet chosen, picked before the high cell.
- R3: For i from 0 to N_PAIRS-1, pair i joins the i-th smallest cell with the i-th largest cell. The pairs are produced in ascending i.
- R4: In enrollment each pair produces two beats on hlp_o, qualified by hlp_valid_o: the lower position first, then the higher. Exactly 2·N_PAIRS beats are produced per enrollment.
- R5: Key bit i (key_o[i], with bit 0 for pair 0) is 1 when the count at the lower position of pair i is strictly greater than the count at the higher position, and 0 otherwise.
- R6: In regeneration (regen_i high at start), hlp_rdy_o is high while the block waits for a helper position, and one beat on hlp_valid_i is taken while it is high. Beats 2i and 2i+1 form pair i. Bit i is 1 when the count at the first position is strictly greater than the count at the second. With unchanged counts and the enrollment helper stream, the result is the enrollment key.
- R7: A regeneration run produces no beats on hlp_valid_o.
- R8: key_o is cleared when a run starts. done_o is high for exactly one cycle at the end of a run, and busy_o is low in the following cycle. key_o then holds its value until the next start.
- R9: After reset, busy_o, done_o, hlp_valid_o and hlp_rdy_o are 0 and key_o is all zeros.
- R10: In regeneration, a helper position that matches no loaded cell reads as a count of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a run when idle |
| regen_i | input | 1 | Run type latched at start: 0 enroll, 1 regenerate |
| cnt_valid_i | input | 1 | Count beat valid |
| cnt_i | input | CNT_W | Cell count |
| pos_i | input | 16 | Cell position of the count |
| hlp_valid_i | input | 1 | Helper position beat valid (regeneration) |
| hlp_i | input | 16 | Helper position in |
| hlp_rdy_o | output | 1 | Block waits for a helper position |
| hlp_valid_o | output | 1 | Helper position beat out (enrollment) |
| hlp_o | output | 16 | Helper position out |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |
| key_o | output | N_PAIRS | Key bits, bit i from pair i |

## Verification
The bench builds the block with N_CELLS = 13, N_PAIRS = 5 and CNT_W = 6. Three cells are always left unselected, so the pick of extremes is actually tested instead of being trivially complete. The narrow count field makes ties common in the random runs, which exercises the position tie-break in both the low pick and the high pick. The same small sizes also allow an all-equal count set, regeneration with swapped and unknown positions, and a start held high through loading, with many enroll/regenerate rounds inside a short run.

// File: rtl/pmk_pkg.sv
package pmk_pkg;
  localparam int POS_W = 16;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_LOAD,
    ST_SEL_LO,
    ST_SEL_HI,
    ST_EMIT_A,
    ST_EMIT_B,
    ST_HLP_WAIT,
    ST_FETCH,
    ST_FINISH
  } pmk_state_e;
endpackage

// File: rtl/pmk_cell_store.sv
module pmk_cell_store #(
  parameter int N_CELLS = 270,
  parameter int CNT_W   = 8,
  parameter int POS_W   = 16,
  parameter int IDX_W   = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [CNT_W-1:0] wr_cnt_i,
  input  logic [POS_W-1:0] wr_pos_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [CNT_W-1:0] rd_cnt_o,
  output logic [POS_W-1:0] rd_pos_o,
  output logic             rd_used_o,
  input  logic             used_clr_i,
  input  logic             used_set_i,
  input  logic [IDX_W-1:0] used_idx_i
);
  logic [CNT_W-1:0] cnt_arr [N_CELLS];
  logic [POS_W-1:0] pos_arr [N_CELLS];
  logic [N_CELLS-1:0] used_vec;

  for (genvar g = 0; g < N_CELLS; g++) begin : g_cell
    logic [CNT_W-1:0] cnt_q;
    logic [POS_W-1:0] pos_q;
    logic             used_q;

    always_ff @(posedge clk_i) begin
      if (wr_i && wr_idx_i == IDX_W'(g)) begin
        cnt_q <= wr_cnt_i;
        pos_q <= wr_pos_i;
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   used_q <= 1'b0;
      else if (used_clr_i)                           used_q <= 1'b0;
      else if (used_set_i && used_idx_i == IDX_W'(g)) used_q <= 1'b1;
    end

    assign cnt_arr[g]  = cnt_q;
    assign pos_arr[g]  = pos_q;
    assign used_vec[g] = used_q;
  end

  assign rd_cnt_o  = cnt_arr[rd_idx_i];
  assign rd_pos_o  = pos_arr[rd_idx_i];
  assign rd_used_o = used_vec[rd_idx_i];
endmodule

// File: rtl/pmk_extreme_scan.sv
module pmk_extreme_scan #(
  parameter int CNT_W = 8,
  parameter int POS_W = 16,
  parameter int IDX_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic             max_i,
  input  logic             cand_ok_i,
  input  logic [IDX_W-1:0] cand_idx_i,
  input  logic [CNT_W-1:0] cand_cnt_i,
  input  logic [POS_W-1:0] cand_pos_i,
  output logic [IDX_W-1:0] res_idx_o,
  output logic [CNT_W-1:0] res_cnt_o,
  output logic [POS_W-1:0] res_pos_o
);
  logic             best_vld_q;
  logic [IDX_W-1:0] best_idx_q;
  logic [CNT_W-1:0] best_cnt_q;
  logic [POS_W-1:0] best_pos_q;
  logic             cand_below, best_below, beats, take;

  // strict rank order: count first, lower position is smaller on a tie
  assign cand_below = (cand_cnt_i < best_cnt_q) ||
                      (cand_cnt_i == best_cnt_q && cand_pos_i < best_pos_q);
  assign best_below = (best_cnt_q < cand_cnt_i) ||
                      (best_cnt_q == cand_cnt_i && best_pos_q < cand_pos_i);
  assign beats = max_i ? best_below : cand_below;
  assign take  = en_i && cand_ok_i && (!best_vld_q || beats);

  assign res_idx_o = take ? cand_idx_i : best_idx_q;
  assign res_cnt_o = take ? cand_cnt_i : best_cnt_q;
  assign res_pos_o = take ? cand_pos_i : best_pos_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      best_vld_q <= 1'b0;
      best_idx_q <= '0;
      best_cnt_q <= '0;
      best_pos_q <= '0;
    end else if (clr_i) begin
      best_vld_q <= 1'b0;
    end else if (take) begin
      best_vld_q <= 1'b1;
      best_idx_q <= cand_idx_i;
      best_cnt_q <= cand_cnt_i;
      best_pos_q <= cand_pos_i;
    end
  end
endmodule

// File: rtl/pmk_key_extractor.sv
module pmk_key_extractor
  import pmk_pkg::*;
#(
  parameter int N_CELLS = 270,
  parameter int N_PAIRS = 128,
  parameter int CNT_W   = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               regen_i,
  input  logic               cnt_valid_i,
  input  logic [CNT_W-1:0]   cnt_i,
  input  logic [POS_W-1:0]   pos_i,
  input  logic               hlp_valid_i,
  input  logic [POS_W-1:0]   hlp_i,
  output logic               hlp_rdy_o,
  output logic               hlp_valid_o,
  output logic [POS_W-1:0]   hlp_o,
  output logic               busy_o,
  output logic               done_o,
  output logic [N_PAIRS-1:0] key_o
);
  localparam int IDX_W  = (N_CELLS > 1) ? $clog2(N_CELLS) : 1;
  localparam int PAIR_W = (N_PAIRS > 1) ? $clog2(N_PAIRS) : 1;
  localparam logic [IDX_W-1:0]  LAST_IDX  = IDX_W'(N_CELLS - 1);
  localparam logic [PAIR_W-1:0] LAST_PAIR = PAIR_W'(N_PAIRS - 1);

  pmk_state_e         state_q;
  logic               regen_q, half_q;
  logic [IDX_W-1:0]   idx_q;
  logic [PAIR_W-1:0]  pair_q;
  logic [CNT_W-1:0]   lo_cnt_q, hi_cnt_q, hit_cnt_q, a_cnt_q;
  logic [POS_W-1:0]   lo_pos_q, hi_pos_q, tgt_q;
  logic [N_PAIRS-1:0] key_q;
  logic               hlp_valid_q;
  logic [POS_W-1:0]   hlp_q;

  logic [CNT_W-1:0] rd_cnt, res_cnt, fetch_cnt;
  logic [POS_W-1:0] rd_pos, res_pos;
  logic [IDX_W-1:0] res_idx;
  logic             rd_used, in_sel, scan_last, start_ok, lo_first;

  assign start_ok  = (state_q == ST_IDLE) && start_i;
  assign in_sel    = (state_q == ST_SEL_LO) || (state_q == ST_SEL_HI);
  assign scan_last = (idx_q == LAST_IDX);
  assign lo_first  = lo_pos_q < hi_pos_q;
  assign fetch_cnt = (rd_pos == tgt_q) ? rd_cnt : hit_cnt_q;

  pmk_cell_store #(
    .N_CELLS(N_CELLS), .CNT_W(CNT_W), .POS_W(POS_W), .IDX_W(IDX_W)
  ) u_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (state_q == ST_LOAD && cnt_valid_i),
    .wr_idx_i   (idx_q),
    .wr_cnt_i   (cnt_i),
    .wr_pos_i   (pos_i),
    .rd_idx_i   (idx_q),
    .rd_cnt_o   (rd_cnt),
    .rd_pos_o   (rd_pos),
    .rd_used_o  (rd_used),
    .used_clr_i (start_ok),
    .used_set_i (in_sel && scan_last),
    .used_idx_i (res_idx)
  );

  pmk_extreme_scan #(
    .CNT_W(CNT_W), .POS_W(POS_W), .IDX_W(IDX_W)
  ) u_scan (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      ((in_sel && scan_last) || state_q == ST_LOAD),
    .en_i       (in_sel),
    .max_i      (state_q == ST_SEL_HI),
    .cand_ok_i  (!rd_used),
    .cand_idx_i (idx_q),
    .cand_cnt_i (rd_cnt),
    .cand_pos_i (rd_pos),
    .res_idx_o  (res_idx),
    .res_cnt_o  (res_cnt),
    .res_pos_o  (res_pos)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      regen_q     <= 1'b0;
      half_q      <= 1'b0;
      idx_q       <= '0;
      pair_q      <= '0;
      lo_cnt_q    <= '0;
      hi_cnt_q    <= '0;
      hit_cnt_q   <= '0;
      a_cnt_q     <= '0;
      lo_pos_q    <= '0;
      hi_pos_q    <= '0;
      tgt_q       <= '0;
      key_q       <= '0;
      hlp_valid_q <= 1'b0;
      hlp_q       <= '0;
    end else begin
      hlp_valid_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          regen_q <= regen_i;
          key_q   <= '0;
          idx_q   <= '0;
          pair_q  <= '0;
          half_q  <= 1'b0;
          state_q <= ST_LOAD;
        end
        ST_LOAD: if (cnt_valid_i) begin
          if (scan_last) begin
            idx_q   <= '0;
            state_q <= regen_q ? ST_HLP_WAIT : ST_SEL_LO;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        ST_SEL_LO: begin
          if (scan_last) begin
            lo_cnt_q <= res_cnt;
            lo_pos_q <= res_pos;
            idx_q    <= '0;
            state_q  <= ST_SEL_HI;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        ST_SEL_HI: begin
          if (scan_last) begin
            hi_cnt_q <= res_cnt;
            hi_pos_q <= res_pos;
            idx_q    <= '0;
            state_q  <= ST_EMIT_A;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        ST_EMIT_A: begin
          hlp_valid_q   <= 1'b1;
          hlp_q         <= lo_first ? lo_pos_q : hi_pos_q;
          key_q[pair_q] <= lo_first ? (lo_cnt_q > hi_cnt_q) : (hi_cnt_q > lo_cnt_q);
          state_q       <= ST_EMIT_B;
        end
        ST_EMIT_B: begin
          hlp_valid_q <= 1'b1;
          hlp_q       <= lo_first ? hi_pos_q : lo_pos_q;
          if (pair_q == LAST_PAIR) begin
            state_q <= ST_FINISH;
          end else begin
            pair_q  <= pair_q + 1'b1;
            state_q <= ST_SEL_LO;
          end
        end
        ST_HLP_WAIT: if (hlp_valid_i) begin
          tgt_q     <= hlp_i;
          hit_cnt_q <= '0;
          idx_q     <= '0;
          state_q   <= ST_FETCH;
        end
        ST_FETCH: begin
          hit_cnt_q <= fetch_cnt;
          if (scan_last) begin
            idx_q <= '0;
            if (!half_q) begin
              a_cnt_q <= fetch_cnt;
              half_q  <= 1'b1;
              state_q <= ST_HLP_WAIT;
            end else begin
              key_q[pair_q] <= a_cnt_q > fetch_cnt;
              half_q        <= 1'b0;
              if (pair_q == LAST_PAIR) begin
                state_q <= ST_FINISH;
              end else begin
                pair_q  <= pair_q + 1'b1;
                state_q <= ST_HLP_WAIT;
              end
            end
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        ST_FINISH: state_q <= ST_IDLE;
        default:   state_q <= ST_IDLE;
      endcase
    end
  end

  assign hlp_rdy_o   = (state_q == ST_HLP_WAIT);
  assign hlp_valid_o = hlp_valid_q;
  assign hlp_o       = hlp_q;
  assign busy_o      = (state_q != ST_IDLE);
  assign done_o      = (state_q == ST_FINISH);
  assign key_o       = key_q;
endmodule

// File: rtl/pmk_key_extractor_chk.sv
module pmk_key_extractor_chk #(
  parameter int N_PAIRS = 128
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               start_i,
  input logic               regen_i,
  input logic               hlp_valid_o,
  input logic [15:0]        hlp_o,
  input logic               busy_o,
  input logic               done_o,
  input logic [N_PAIRS-1:0] key_o
);
  logic        run_regen_q, odd_q;
  logic [31:0] beats_q;
  logic [15:0] prev_pos_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_regen_q <= 1'b0;
      odd_q       <= 1'b0;
      beats_q     <= '0;
      prev_pos_q  <= '0;
    end else if (!busy_o && start_i) begin
      run_regen_q <= regen_i;
      odd_q       <= 1'b0;
      beats_q     <= '0;
    end else if (hlp_valid_o) begin
      odd_q      <= !odd_q;
      beats_q    <= beats_q + 1;
      prev_pos_q <= hlp_o;
    end
  end

  AST_BUSY_AFTER_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && start_i |=> busy_o); // R1
  AST_PAIR_ASCENDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hlp_valid_o && odd_q |-> hlp_o > prev_pos_q); // R4
  AST_BEAT_TOTAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !run_regen_q |-> beats_q + (hlp_valid_o ? 32'd1 : 32'd0) == 32'(2 * N_PAIRS)); // R4
  AST_REGEN_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && run_regen_q |-> !hlp_valid_o); // R7
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && !busy_o); // R8
  AST_KEY_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && !start_i |=> $stable(key_o)); // R8
  AST_KEY_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && start_i |=> key_o == '0); // R8
endmodule

bind pmk_key_extractor pmk_key_extractor_chk #(.N_PAIRS(N_PAIRS)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .regen_i     (regen_i),
  .hlp_valid_o (hlp_valid_o),
  .hlp_o       (hlp_o),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .key_o       (key_o)
);

// File: tb/pmk_key_extractor_test.sv
module pmk_key_extractor_test;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 13;
  localparam int K  = 5;
  localparam int CW = 6;
  localparam int WATCHDOG = 150000;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic          start_i = 0, regen_i = 0, cnt_valid_i = 0, hlp_valid_i = 0;
  logic [CW-1:0] cnt_i = '0;
  logic [15:0]   pos_i = '0, hlp_i = '0;
  logic          hlp_rdy_o, hlp_valid_o, busy_o, done_o;
  logic [15:0]   hlp_o;
  logic [K-1:0]  key_o;

  pmk_key_extractor #(.N_CELLS(N), .N_PAIRS(K), .CNT_W(CW)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .regen_i(regen_i),
    .cnt_valid_i(cnt_valid_i), .cnt_i(cnt_i), .pos_i(pos_i),
    .hlp_valid_i(hlp_valid_i), .hlp_i(hlp_i), .hlp_rdy_o(hlp_rdy_o),
    .hlp_valid_o(hlp_valid_o), .hlp_o(hlp_o), .busy_o(busy_o),
    .done_o(done_o), .key_o(key_o)
  );

  int checks = 0, fails = 0, cycles = 0, hb_n = 0;
  logic [CW-1:0] c_cnt [N];
  logic [15:0]   c_pos [N];
  logic [15:0]   hb    [2*K+4];
  logic [15:0]   exp_h [2*K];
  logic [15:0]   alt_h [2*K];
  logic [K-1:0]  exp_key, alt_key;

  always @(negedge clk) if (hlp_valid_o) begin
    if (hb_n < 2*K+4) hb[hb_n] = hlp_o;
    hb_n++;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles == WATCHDOG) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=%0d expected<%0d", cycles, WATCHDOG);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit below(int a, int b);
    return (c_cnt[a] < c_cnt[b]) || (c_cnt[a] == c_cnt[b] && c_pos[a] < c_pos[b]);
  endfunction

  function automatic logic [CW-1:0] cnt_at(logic [15:0] p);
    for (int j = 0; j < N; j++) if (c_pos[j] == p) return c_cnt[j];
    return '0; // R10
  endfunction

  // R2 R3 R5 expected helper stream and key
  task automatic model();
    bit used [N];
    for (int j = 0; j < N; j++) used[j] = 0;
    for (int p = 0; p < K; p++) begin
      int lo = -1, hi = -1, f, s;
      for (int j = 0; j < N; j++) if (!used[j] && (lo < 0 || below(j, lo))) lo = j;
      used[lo] = 1;
      for (int j = 0; j < N; j++) if (!used[j] && (hi < 0 || below(hi, j))) hi = j;
      used[hi] = 1;
      f = (c_pos[lo] < c_pos[hi]) ? lo : hi;
      s = (f == lo) ? hi : lo;
      exp_h[2*p]   = c_pos[f];
      exp_h[2*p+1] = c_pos[s];
      exp_key[p]   = c_cnt[f] > c_cnt[s];
    end
  endtask

  task automatic load_cells(input bit hold_start);
    for (int i = 0; i < N; i++) begin
      @(negedge clk);
      if (i == 0) chk(busy_o == 1'b1, "R1 busy after start", busy_o, 1);
      cnt_valid_i = 1; cnt_i = c_cnt[i]; pos_i = c_pos[i]; start_i = hold_start;
    end
    @(negedge clk);
    cnt_valid_i = 0; start_i = 0;
  endtask

  task automatic wait_done();
    int guard = 0;
    while (!done_o && guard < 5000) begin @(negedge clk); guard++; end
    @(negedge clk);
    chk(!busy_o && !done_o, "R8 idle after done", {busy_o, done_o}, 0);
  endtask

  task automatic enroll(input bit hold_start);
    hb_n = 0;
    @(negedge clk); start_i = 1; regen_i = 0;
    load_cells(hold_start);
    wait_done();
    model();
    chk(hb_n == 2*K, "R4 helper beat count", hb_n, 2*K);
    for (int b = 0; b < 2*K && b < hb_n; b++)
      chk(hb[b] == exp_h[b], "R3 helper position", hb[b], exp_h[b]);
    chk(key_o == exp_key, "R5 enrolled key", key_o, exp_key);
  endtask

  task automatic regen(input logic [15:0] h [2*K], input logic [K-1:0] want, input string req);
    hb_n = 0;
    @(negedge clk); start_i = 1; regen_i = 1;
    load_cells(1'b0);
    regen_i = 0;
    for (int b = 0; b < 2*K; b++) begin
      while (!hlp_rdy_o) @(negedge clk);
      hlp_valid_i = 1; hlp_i = h[b];
      @(negedge clk);
      hlp_valid_i = 0;
    end
    wait_done();
    chk(key_o == want, req, key_o, want);
    chk(hb_n == 0, "R7 no helper out in regen", hb_n, 0);
  endtask

  task automatic rand_cells(input int cmax);
    int base = $urandom_range(0, 60000);
    for (int i = 0; i < N; i++) begin
      c_pos[i] = 16'(base + 3*i);
      c_cnt[i] = CW'($urandom_range(0, cmax));
    end
    for (int i = N-1; i > 0; i--) begin
      int j = $urandom_range(0, i);
      logic [15:0] t = c_pos[i];
      c_pos[i] = c_pos[j]; c_pos[j] = t;
    end
  endtask

  initial begin
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    chk(!busy_o && !done_o && !hlp_valid_o && !hlp_rdy_o, "R9 reset outputs",
        {busy_o, done_o, hlp_valid_o, hlp_rdy_o}, 0);
    chk(key_o == '0, "R9 reset key", key_o, 0);
    rst_ni = 1;

    // directed distinct counts
    for (int i = 0; i < N; i++) begin
      c_pos[i] = 16'h0065 + 16'(i);
      c_cnt[i] = CW'((i * 23 + 7) % 61);
    end
    enroll(1'b0);
    regen(exp_h, exp_key, "R6 regen reproduces key");

    // all counts equal: position tie-break, all key bits 0
    for (int i = 0; i < N; i++) c_cnt[i] = 6'd7;
    enroll(1'b0);
    chk(exp_key == '0, "R2 tie key zero", exp_key, 0);
    chk(exp_h[0] == 16'h0065 && exp_h[1] == 16'h0065 + 16'(N-1), "R2 tie extremes",
        {exp_h[0], exp_h[1]}, {16'h0065, 16'h0065 + 16'(N-1)});

    // random rounds, one with start held high during loading (R1 ignored)
    for (int r = 0; r < 6; r++) begin
      rand_cells((r % 2) ? 3 : 63);
      enroll(r == 2);
      regen(exp_h, exp_key, "R6 regen reproduces key");
    end

    // regen with swapped pairs and one unknown position (R10)
    for (int p = 0; p < K; p++) begin
      alt_h[2*p] = exp_h[2*p+1]; alt_h[2*p+1] = exp_h[2*p];
    end
    alt_h[3] = 16'hFFFF;
    for (int p = 0; p < K; p++) alt_key[p] = cnt_at(alt_h[2*p]) > cnt_at(alt_h[2*p+1]);
    regen(alt_h, alt_key, "R10 regen swapped and unknown position");

    // key held while idle
    repeat (6) @(negedge clk);
    chk(key_o == alt_key && !busy_o, "R8 key held while idle", key_o, alt_key);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule